// File: doc/BRIEF.md
# Memory-Based Fixed Delay Line

This block delays a narrow data stream by a fixed number of clock cycles. The default is a 1-bit stream delayed by 400 cycles. The history lives in a small inferred memory and not in a chain of flip-flops.

A single address counter sweeps the memory once per period. Each cycle the memory reads out the old word at the current address and stores the new sample in the same place. A location is therefore revisited exactly one period after it was written. The period is the requested delay less the one cycle taken by the registered memory read. The output register supplies the remaining cycle.

After a synchronous reset the output is held at zero until data written after the reset has come through the memory. Stale memory contents never reach the output. A parameter selects how the address is generated: a down-counter that reloads when its decrement borrows, or an up-counter cleared by a greater-or-equal compare. Both give the same output.

Top module: `fixed_delay_line`

## Requirements
- R1: Once filled, `dly_out` equals the value of `dly_in` sampled exactly DELAY rising clock edges earlier, on every lane of the WIDTH-bit word.
- R2: After reset is released, `dly_out` is all zeros for the first DELAY clock edges. During this time nothing written before the reset appears at the output.
- R3: In the default mode the memory address steps down by one on each cycle out of reset. After address 0 it reloads DELAY-2, so every address in 0..DELAY-2 is revisited once per DELAY-1 cycles.
- R4: A synchronous reset asserted in the middle of a stream does two things. The output is zero on the edge after reset is seen. The history is discarded, so R2 applies again from the release.
- R5: The up-counting address mode (counter cleared by a greater-or-equal compare at DELAY-2) produces an output identical to the default mode.
- R6: The smallest supported delay, DELAY=3, meets R1 and R2 with a WIDTH of 2.
- R7: Elaboration is rejected when DELAY is below 3 or when DELAY-1 exceeds the memory depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dly_in | input | WIDTH | Sample entering the delay line |
| dly_out | output | WIDTH | Sample delayed by DELAY cycles, zero while filling |

## Verification
Two situations are hard to reach from the ports. The first is the boundary where the address wraps. An off-by-one in the reload value shows only as a delay one cycle too short or too long. For this reason the stream runs across several complete periods, and the expected value comes from a queue of exactly DELAY entries. The second is stale data left in the memory when reset is asserted mid-stream. The stimulus fills the memory with a dense pattern of ones before the reset, so any ungated old word after the release would show up as a 1 where the model expects 0.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

    typedef enum logic [0:0] {
        ADDR_DOWN_RELOAD = 1'b0,
        ADDR_UP_COMPARE  = 1'b1
    } addr_mode_e;

    // One cycle of registered memory read sits inside the loop.
    localparam int unsigned READ_LATENCY = 1;

    // Number of cycles between visits to the same memory word.
    function automatic int unsigned sweep_period(input int unsigned delay);
        return delay - READ_LATENCY;
    endfunction

endpackage

// File: rtl/fdl_addr_gen.sv
module fdl_addr_gen
    import fdl_pkg::*;
#(
    parameter int unsigned AW     = 9,
    parameter int unsigned PERIOD = 399,
    parameter addr_mode_e  MODE   = ADDR_DOWN_RELOAD
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] addr_o,
    output logic          wrap_o
);

    localparam logic [AW-1:0] LAST = AW'(PERIOD - 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
    } ag_state_t;

    ag_state_t st_d, st_q;

    if (MODE == ADDR_DOWN_RELOAD) begin : g_down
        logic [AW:0] dec;
        logic        borrow;

        always_comb begin
            dec    = {1'b0, st_q.cnt} - {{AW{1'b0}}, 1'b1};
            borrow = dec[AW];
            st_d   = st_q;
            st_d.cnt = borrow ? LAST : dec[AW-1:0];
        end

        always_ff @(posedge clk) begin
            if (rst) st_q.cnt <= LAST;
            else     st_q     <= st_d;
        end

        assign wrap_o = borrow;

        p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
            (st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
        p_addr_reload_r3: assert property (@(posedge clk) disable iff (rst)
            (st_q.cnt == '0) |=> (st_q.cnt == LAST));
    end else begin : g_up
        logic at_end;

        always_comb begin
            at_end = (st_q.cnt >= LAST);
            st_d   = st_q;
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) st_q.cnt <= '0;
            else     st_q     <= st_d;
        end

        assign wrap_o = at_end;

        p_addr_up_step_r5: assert property (@(posedge clk) disable iff (rst)
            (st_q.cnt < LAST) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
        p_addr_up_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (st_q.cnt == LAST) |=> (st_q.cnt == '0));
    end

    assign addr_o = st_q.cnt;

    p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
        addr_o <= LAST);

endmodule

// File: rtl/fdl_store.sv
module fdl_store #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 512,
    parameter int unsigned AW    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    // Read-before-write on one shared address: the old word is captured
    // on the same edge that stores the new one.
    always_ff @(posedge clk) begin
        if (!rst) begin
            rd_q         <= mem[addr_i];
            mem[addr_i]  <= wdata_i;
        end
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/fdl_out_stage.sv
module fdl_out_stage #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap_i,
    input  logic [WIDTH-1:0] rdata_i,
    output logic [WIDTH-1:0] dout_o
);

    typedef struct packed {
        logic             filled;
        logic             rd_vld;
        logic [WIDTH-1:0] dout;
    } os_state_t;

    os_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.filled = st_q.filled | wrap_i;
        st_d.rd_vld = st_q.filled;
        st_d.dout   = st_q.rd_vld ? rdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_o = st_q.dout;

    p_gate_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !st_q.rd_vld |=> (dout_o == '0));
    p_fill_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.filled |=> st_q.filled);
    p_reset_clears_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout_o == '0 && !st_q.rd_vld));

endmodule

// File: rtl/fixed_delay_line.sv
module fixed_delay_line
    import fdl_pkg::*;
#(
    parameter int unsigned WIDTH     = 1,
    parameter int unsigned DELAY     = 400,
    parameter int unsigned DEPTH     = 512,
    parameter addr_mode_e  ADDR_MODE = ADDR_DOWN_RELOAD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] dly_in,
    output logic [WIDTH-1:0] dly_out
);

    localparam int unsigned PERIOD = sweep_period(DELAY);
    localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // R7: reject delays the single-address sweep cannot realise.
    if (DELAY < 3 || PERIOD > DEPTH) begin : g_bad_delay
        $error("fixed_delay_line: DELAY out of range for DEPTH");
    end

    logic [AW-1:0]    addr;
    logic             wrap;
    logic [WIDTH-1:0] rdata;

    fdl_addr_gen #(
        .AW     (AW),
        .PERIOD (PERIOD),
        .MODE   (ADDR_MODE)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .addr_o (addr),
        .wrap_o (wrap)
    );

    fdl_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (addr),
        .wdata_i (dly_in),
        .rdata_o (rdata)
    );

    fdl_out_stage #(
        .WIDTH (WIDTH)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .rdata_i (rdata),
        .dout_o  (dly_out)
    );

endmodule

// File: tb/fixed_delay_line_tb.sv
module fixed_delay_line_tb;
    import fdl_pkg::*;

    localparam int unsigned D_MAIN = 400;
    localparam int unsigned D_MIN  = 3;
    localparam int unsigned WDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [1:0] din2 = 2'b00;
    logic       out_main, out_up;
    logic [1:0] out_min;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int since_rst = 0;
    bit mid_reset_seen = 1'b0;

    always #5 clk = ~clk;

    fixed_delay_line #(.WIDTH(1), .DELAY(D_MAIN)) u_dut (
        .clk(clk), .rst(rst), .dly_in(din), .dly_out(out_main));

    fixed_delay_line #(.WIDTH(1), .DELAY(D_MAIN), .ADDR_MODE(ADDR_UP_COMPARE)) u_dut_up (
        .clk(clk), .rst(rst), .dly_in(din), .dly_out(out_up));

    fixed_delay_line #(.WIDTH(2), .DELAY(D_MIN), .DEPTH(4)) u_dut_min (
        .clk(clk), .rst(rst), .dly_in(din2), .dly_out(out_min));

    // Behavioural reference: queues of exactly DELAY entries.
    logic       q_main [$];
    logic [1:0] q_min  [$];
    logic       exp_main = 1'b0;
    logic [1:0] exp_min  = 2'b00;

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, expv);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            q_main.delete();
            q_min.delete();
            for (int i = 0; i < D_MAIN; i++) q_main.push_back(1'b0);
            for (int i = 0; i < D_MIN; i++)  q_min.push_back(2'b00);
            exp_main  = 1'b0;
            exp_min   = 2'b00;
            since_rst = 0;
        end else begin
            q_main.push_back(din);
            q_min.push_back(din2);
            exp_main = q_main.pop_front();
            exp_min  = q_min.pop_front();
            since_rst++;
        end
    endtask

    task automatic step(input int pattern);
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        if (rst) begin
            check("R4 reset forces zero", {1'b0, out_main}, 2'b00);
        end else if (since_rst <= D_MAIN) begin
            if (mid_reset_seen) check("R4 history discarded", {1'b0, out_main}, {1'b0, exp_main});
            else                check("R2 fill zeros", {1'b0, out_main}, {1'b0, exp_main});
        end else begin
            check("R1/R3 exact delay", {1'b0, out_main}, {1'b0, exp_main});
        end
        check("R5 up-count mode", {1'b0, out_up}, {1'b0, exp_main});
        check("R6 minimum delay", out_min, exp_min);
        case (pattern)
            0: begin din = 1'($urandom); din2 = 2'($urandom); end
            1: begin din = 1'b1;         din2 = 2'b11;        end
            2: begin din = cyc[0];       din2 = {cyc[0], ~cyc[0]}; end
            default: begin din = (cyc % 7 == 0); din2 = 2'(cyc % 4); end
        endcase
    endtask

    initial begin
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(0);
        check("R2 reset state", {1'b0, out_main}, 2'b00);
        rst = 1'b0;
        for (int i = 0; i < 1300; i++) step(0);
        for (int i = 0; i < 500; i++)  step(2);
        for (int i = 0; i < 500; i++)  step(3);
        for (int i = 0; i < 450; i++)  step(1);
        rst = 1'b1;
        mid_reset_seen = 1'b1;
        for (int i = 0; i < 3; i++) step(1);
        rst = 1'b0;
        for (int i = 0; i < 1400; i++) step(0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired after %0d cycles", WDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule